// File: doc/BRIEF.md
# Eight-Account Balance Ledger

The block holds a small bank of unsigned balances, eight accounts of 8 bits each. Every clock cycle it takes one request: an account number, a request kind and an amount. The request can read a balance, add the amount to it or take the amount away from it.

An add that would push the balance past 255 is refused. A take that is larger than the balance is also refused. A refused request leaves the stored value as it was.

The status and the balance outputs are combinational. They come from the request on the inputs and from the stored value of the selected account, so a caller sees the outcome in the same cycle it presents the request. An accepted change is written on the next rising clock edge, so the following request already sees it.

Top module: `ledger_bank`

## Requirements
- R1: While `rst_ni` is low, every account is cleared to 0. After reset, a read of any account returns 0.
- R2: Kind `2'b00` is a read. It reports status `2'b00` and the stored balance. The amount has no effect, and the balance stays the same.
- R3: Kind `2'b11` is reserved and behaves exactly as a read: status `2'b00`, stored balance shown, nothing changed.
- R4: Kind `2'b01` adds the amount. If the sum is at most 255, it reports status `2'b01` and shows the sum, and the sum is stored at the next rising edge.
- R5: An add that lands exactly on 255 is accepted with status `2'b01`.
- R6: An add whose sum would exceed 255 reports status `2'b10` and shows the unchanged balance. The stored value is kept.
- R7: Kind `2'b10` takes the amount away. If the amount is at most the balance, it reports status `2'b01` and shows the difference, and the difference is stored at the next rising edge.
- R8: A take equal to the whole balance is accepted and leaves 0.
- R9: A take larger than the balance reports status `2'b11` and shows the unchanged balance. The stored value is kept.
- R10: A request touches only the account it selects. The seven other balances are unaffected.
- R11: Requests may arrive back to back, one per cycle. Each request sees the value committed by the one before it on the same account.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; updates commit on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all balances |
| acct_i | input | 3 | Account selected by this cycle's request |
| kind_i | input | 2 | Request kind: 00 read, 01 add, 10 take, 11 reserved (read) |
| amount_i | input | 8 | Unsigned amount for add or take |
| status_o | output | 2 | 00 read, 01 accepted, 10 add refused, 11 take refused |
| balance_o | output | 8 | Resulting balance if accepted, otherwise the stored balance |

## Verification
The properties assume that the request inputs are stable and defined for the whole cycle, since the outputs follow them combinationally. They also assume that one request is presented per cycle and that it is held only until the next rising edge. The bench therefore changes the inputs only on falling edges. Between batches of work it parks the inputs on a read, so that a held add or take is not applied twice. The carry-over property compares a balance with the one shown a cycle earlier on the same account. It only becomes active one full cycle after reset is released, so that no value seen during reset is treated as a committed balance.

// File: rtl/ledger_pkg.sv
package ledger_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_ADD   = 2'b01,
    KIND_TAKE  = 2'b10,
    KIND_RSVD  = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    ST_READ    = 2'b00,
    ST_OK      = 2'b01,
    ST_OVER    = 2'b10,
    ST_UNDER   = 2'b11
  } status_e;
endpackage

// File: rtl/ledger_store.sv
module ledger_store #(
  parameter int N_ACCT = 8,
  parameter int W      = 8,
  localparam int SW    = (N_ACCT > 1) ? $clog2(N_ACCT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [SW-1:0] rd_sel_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] bal_q [N_ACCT];

  for (genvar g = 0; g < N_ACCT; g++) begin : g_acct
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 bal_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == SW'(g))      bal_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_ACCT; i++)
      if (rd_sel_i == SW'(i)) rd_data_o = bal_q[i];
  end
endmodule

// File: rtl/ledger_decide.sv
module ledger_decide
  import ledger_pkg::*;
#(
  parameter int W = 8
) (
  input  kind_e         kind_i,
  input  logic [W-1:0]  amount_i,
  input  logic [W-1:0]  cur_i,
  output status_e       status_o,
  output logic [W-1:0]  next_o,
  output logic          wr_en_o
);
  logic [W:0] sum;
  logic [W:0] diff;

  // shared W+1 bit arithmetic; the top bit flags overflow / borrow
  assign sum  = {1'b0, cur_i} + {1'b0, amount_i};
  assign diff = {1'b0, cur_i} - {1'b0, amount_i};

  always_comb begin
    status_o = ST_READ;
    next_o   = cur_i;
    wr_en_o  = 1'b0;
    unique case (kind_i)
      KIND_ADD: begin
        if (sum[W]) status_o = ST_OVER;
        else begin
          status_o = ST_OK;
          next_o   = sum[W-1:0];
          wr_en_o  = 1'b1;
        end
      end
      KIND_TAKE: begin
        if (diff[W]) status_o = ST_UNDER;
        else begin
          status_o = ST_OK;
          next_o   = diff[W-1:0];
          wr_en_o  = 1'b1;
        end
      end
      default: ; // read and reserved
    endcase
  end
endmodule

// File: rtl/ledger_bank.sv
module ledger_bank
  import ledger_pkg::*;
#(
  parameter int N_ACCT = 8,
  parameter int W      = 8,
  localparam int SW    = (N_ACCT > 1) ? $clog2(N_ACCT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] acct_i,
  input  logic [1:0]    kind_i,
  input  logic [W-1:0]  amount_i,
  output logic [1:0]    status_o,
  output logic [W-1:0]  balance_o
);
  logic [W-1:0] cur_bal;
  logic [W-1:0] next_bal;
  logic         wr_en;
  status_e      status;

  ledger_store #(.N_ACCT(N_ACCT), .W(W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sel_i  (acct_i),
    .wr_data_i (next_bal),
    .rd_sel_i  (acct_i),
    .rd_data_o (cur_bal)
  );

  ledger_decide #(.W(W)) u_decide (
    .kind_i   (kind_e'(kind_i)),
    .amount_i (amount_i),
    .cur_i    (cur_bal),
    .status_o (status),
    .next_o   (next_bal),
    .wr_en_o  (wr_en)
  );

  assign status_o  = status;
  assign balance_o = next_bal;
endmodule

// File: rtl/ledger_bank_chk.sv
module ledger_bank_chk #(
  parameter int N_ACCT = 8,
  parameter int W      = 8,
  localparam int SW    = (N_ACCT > 1) ? $clog2(N_ACCT) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [SW-1:0] acct_i,
  input logic [1:0]    kind_i,
  input logic [W-1:0]  amount_i,
  input logic [1:0]    status_o,
  input logic [W-1:0]  balance_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  AST_READ_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == 2'b00 |-> status_o == 2'b00); // R2
  AST_RSVD_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == 2'b11 |-> status_o == 2'b00); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b01 && kind_i == 2'b01) |-> balance_o >= amount_i); // R4
  AST_OVER_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'b10 |-> (kind_i == 2'b01 &&
      ((W+1)'(balance_o) + (W+1)'(amount_i)) > (W+1)'({W{1'b1}}))); // R6
  AST_ACCEPT_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'b01 |-> (kind_i == 2'b01 || kind_i == 2'b10)); // R7
  AST_UNDER_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == 2'b11 |-> (kind_i == 2'b10 && amount_i > balance_o)); // R9
  AST_BAL_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && kind_i == 2'b00 && acct_i == $past(acct_i))
      |-> balance_o == $past(balance_o)); // R11
endmodule

bind ledger_bank ledger_bank_chk #(.N_ACCT(N_ACCT), .W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .acct_i    (acct_i),
  .kind_i    (kind_i),
  .amount_i  (amount_i),
  .status_o  (status_o),
  .balance_o (balance_o)
);

// File: tb/ledger_bank_bench.sv
`timescale 1ns/1ps
module ledger_bank_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] acct_i = '0;
  logic [1:0] kind_i = '0;
  logic [7:0] amount_i = '0;
  logic [1:0] status_o;
  logic [7:0] balance_o;

  typedef struct {
    logic [1:0] st;
    logic [7:0] bal;
    string      tag;
  } exp_t;

  exp_t      q[$];
  int        checks = 0;
  int        fails = 0;
  logic [7:0] model [8];
  bit        done = 0;

  always #4 clk_i = ~clk_i;

  ledger_bank u_ledger_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .acct_i(acct_i), .kind_i(kind_i),
    .amount_i(amount_i), .status_o(status_o), .balance_o(balance_o)
  );

  task automatic req(input logic [2:0] a, input logic [1:0] k,
                     input logic [7:0] amt, input string tag);
    exp_t e;
    int   s;
    @(negedge clk_i);
    acct_i = a; kind_i = k; amount_i = amt;
    e.tag = tag; e.st = 2'b00; e.bal = model[a];
    if (k == 2'b01) begin
      s = int'(model[a]) + int'(amt);
      if (s > 255) e.st = 2'b10;
      else begin e.st = 2'b01; e.bal = 8'(s); model[a] = 8'(s); end
    end else if (k == 2'b10) begin
      if (amt > model[a]) e.st = 2'b11;
      else begin e.st = 2'b01; e.bal = model[a] - amt; model[a] = model[a] - amt; end
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      kind_i = 2'b00;
    end
  endtask

  // monitor: samples mid low phase, before the committing edge
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (status_o !== e.st || balance_o !== e.bal) begin
          fails++;
          $display("FAIL %s: status=%b balance=%0d expected status=%b balance=%0d",
                   e.tag, status_o, balance_o, e.st, e.bal);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 8; i++) req(3'(i), 2'b00, 8'(i * 37), "R1");

    req(3'd2, 2'b01, 8'd100, "R4");
    req(3'd2, 2'b00, 8'd77,  "R2");
    req(3'd2, 2'b11, 8'd200, "R3");
    req(3'd2, 2'b01, 8'd155, "R5");
    req(3'd2, 2'b01, 8'd1,   "R6");
    req(3'd2, 2'b00, 8'd0,   "R6");
    req(3'd2, 2'b10, 8'd55,  "R7");
    req(3'd2, 2'b10, 8'd201, "R9");
    req(3'd2, 2'b00, 8'd0,   "R9");
    req(3'd2, 2'b10, 8'd200, "R8");
    req(3'd2, 2'b10, 8'd1,   "R9");

    req(3'd5, 2'b01, 8'd10, "R11");
    req(3'd5, 2'b01, 8'd20, "R11");
    req(3'd5, 2'b10, 8'd5,  "R11");
    req(3'd5, 2'b01, 8'd30, "R11");
    req(3'd7, 2'b01, 8'd250, "R10");
    for (int i = 0; i < 8; i++) req(3'(i), 2'b00, 8'hff, "R10");

    for (int i = 0; i < 400; i++)
      req(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
          8'($urandom_range(0, 255)), "R11");
    idle(3);

    rst_ni = 1'b0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    idle(2);
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) req(3'(i), 2'b00, 8'd0, "R1");
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule